// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a memory-mapped watchdog timer. It sits on a plain 32-bit register bus with an address, write data, separate read and write strobes, and a read data return. A 32-bit counter is set from a preset held in a load register. While it is enabled, the counter counts down once per clock. When it reaches zero it flags a pending interrupt and starts again from the preset. If the flag has not been cleared by the next time the counter reaches zero, the block can issue a single-cycle reset request.

A lock register guards all other registers. After reset the block is locked, and software must write a fixed 32-bit key before any other register accepts a write. Writing any other value to the lock register locks the block again. The interrupt clear register has a busy bit that software polls. After each accepted clear, a new clear is refused for two cycles.

Top module: `wdog_timer`

## Requirements
- R1: The block leaves reset locked, and bit 0 of the lock register (offset 0x13C) reads 1 while locked. Writing 0x378F0765 to 0x13C unlocks it. Writing any other value locks it. Writes to 0x13C are always accepted.
- R2: While locked, writes to every register other than 0x13C have no effect on any register, counter or flag.
- R3: When bit 0 of the enable register (0x110) is 1, the counter decrements by one each clock. When it is 0, the counter holds its value.
- R4: Any write to the reload register (0x114) copies the load register (0x108) into the counter, whatever the data. The counter value reads back at 0x118.
- R5: When the counter is enabled and at zero, bit 0 of the status register (0x000) is set and the counter reloads from the load register on the same edge.
- R6: When bit 0 of the control register (0x104) is 1 and the counter reaches zero while the status bit is already set, `rst_req_o` is high for the following cycle. When the control bit is 0, `rst_req_o` stays low.
- R7: A write to 0x120 with bit 0 set clears the status bit if the clear-busy flag is low. Bit 1 of 0x120 reads 1 for the two cycles after an accepted clear. A clear written while busy is ignored. A timeout on the same edge as a clear wins.
- R8: `irq_o` equals the status bit when bit 0 of the mask register (0x124) is 0, and is 0 when that mask bit is 1.
- R9: After reset the state is: mask 1, load 0xFFFFFFFF, counter 0xFFFFFFFF, enable 0, control 0, status 0. Reads of unmapped offsets return 0, and `bus_rdata` is 0 while `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, data returned in the same cycle |
| bus_rdata | output | 32 | Read data, zero when no read is active |
| irq_o | output | 1 | Masked timeout interrupt |
| rst_req_o | output | 1 | One-cycle reset request on a second unserviced timeout |

## Verification
Writes are sent both locked and unlocked. This separates the key gate from the register decode, and a wrong key is used to show that only the exact value opens the block. The counter runs with short presets (5, 3 and 2) so that zero crossings, reloads, pending and masked interrupts occur within a few cycles. Reset requests are counted over windows with the control bit on and off, which separates a first timeout from a repeated unserviced one. A clear is read back during its busy window and after it, and the reference model checks the outputs and every read on every clock.

// File: rtl/wdog_pkg.sv
// Shared constants for the watchdog: bus widths, register offsets, unlock key.
// Assumes a byte-addressed 12-bit offset space and 32-bit registers.
package wdog_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_STAT = 12'h000;
    localparam logic [ADDR_W-1:0] OFF_CTRL = 12'h104;
    localparam logic [ADDR_W-1:0] OFF_LOAD = 12'h108;
    localparam logic [ADDR_W-1:0] OFF_EN   = 12'h110;
    localparam logic [ADDR_W-1:0] OFF_RELD = 12'h114;
    localparam logic [ADDR_W-1:0] OFF_VAL  = 12'h118;
    localparam logic [ADDR_W-1:0] OFF_ICLR = 12'h120;
    localparam logic [ADDR_W-1:0] OFF_MASK = 12'h124;
    localparam logic [ADDR_W-1:0] OFF_LOCK = 12'h13C;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h378F0765;
endpackage

// File: rtl/wdog_regs.sv
// Register file with key lock. Decodes bus writes, gates them with the lock
// flag, and builds the read mux. Assumes single-cycle strobes and
// combinational read data.
module wdog_regs
    import wdog_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int DW = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    input  logic [DW-1:0] cnt_val,
    input  logic          stat,
    input  logic          clr_busy,
    output logic          rst_en,
    output logic [DW-1:0] load_val,
    output logic          cnt_en,
    output logic          mask,
    output logic          reload_stb,
    output logic          clr_stb
);
    logic          locked_q;
    logic          wr_open;
    logic [DW-1:0] rd_mux;

    assign wr_open    = bus_wr && !locked_q;
    assign reload_stb = wr_open && (bus_addr == OFF_RELD);
    assign clr_stb    = wr_open && (bus_addr == OFF_ICLR) && bus_wdata[0];

    // Lock flag: always writable, opens only on the exact key.
    always_ff @(posedge clk) begin
        if (!rst_n)
            locked_q <= 1'b1;
        else if (bus_wr && bus_addr == OFF_LOCK)
            locked_q <= (bus_wdata != UNLOCK_KEY);
    end

    // Configuration registers, written only while unlocked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rst_en   <= 1'b0;
            load_val <= '1;
            cnt_en   <= 1'b0;
            mask     <= 1'b1;
        end else if (wr_open) begin
            case (bus_addr)
                OFF_CTRL: rst_en   <= bus_wdata[0];
                OFF_LOAD: load_val <= bus_wdata;
                OFF_EN:   cnt_en   <= bus_wdata[0];
                OFF_MASK: mask     <= bus_wdata[0];
                default:  ;
            endcase
        end
    end

    // Read mux over mapped offsets, zero elsewhere.
    always_comb begin
        case (bus_addr)
            OFF_STAT: rd_mux = DW'(stat);
            OFF_CTRL: rd_mux = DW'(rst_en);
            OFF_LOAD: rd_mux = load_val;
            OFF_EN:   rd_mux = DW'(cnt_en);
            OFF_VAL:  rd_mux = cnt_val;
            OFF_ICLR: rd_mux = DW'({clr_busy, 1'b0});
            OFF_MASK: rd_mux = DW'(mask);
            OFF_LOCK: rd_mux = DW'(locked_q);
            default:  rd_mux = '0;
        endcase
    end

    assign bus_rdata = bus_rd ? rd_mux : '0;

    AST_LOCKED_LOAD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && bus_wr && bus_addr == OFF_LOAD) |=> $stable(load_val)); // R2
    AST_LOCKED_EN_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (locked_q && bus_wr && bus_addr == OFF_EN) |=> $stable(cnt_en)); // R2
    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFF_LOCK && bus_wdata == UNLOCK_KEY) |=> !locked_q); // R1
endmodule

// File: rtl/wdog_counter.sv
// Down-counter. Decrements while enabled, reloads on zero or on a reload
// strobe, and flags the zero event. Assumes the reload strobe is already
// qualified by the lock.
module wdog_counter #(
    parameter int CW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          reload_stb,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] cnt,
    output logic          zero_hit
);
    assign zero_hit = en && (cnt == '0);

    // Count update: reload strobe first, then zero wrap, then decrement.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '1;
        else if (reload_stb)
            cnt <= load_val;
        else if (zero_hit)
            cnt <= load_val;
        else if (en)
            cnt <= cnt - 1'b1;
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !reload_stb) |=> $stable(cnt)); // R3
    AST_RELOAD_COPIES: assert property (@(posedge clk) disable iff (!rst_n)
        reload_stb |=> (cnt == $past(load_val))); // R4
    AST_ZERO_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cnt == '0 && !reload_stb) |=> (cnt == $past(load_val))); // R5
endmodule

// File: rtl/wdog_irq.sv
// Timeout status, clear-busy window and reset request. Assumes zero_hit and
// clr_stb are single-cycle events from the counter and register file.
module wdog_irq #(
    parameter int BUSY_CYC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic zero_hit,
    input  logic rst_en,
    input  logic clr_stb,
    output logic stat,
    output logic clr_busy,
    output logic rst_req
);
    localparam int BW = $clog2(BUSY_CYC + 1);

    logic [BW-1:0] busy_cnt;
    logic          clr_ok;

    assign clr_busy = (busy_cnt != '0);
    assign clr_ok   = clr_stb && !clr_busy;

    // Status flag: a timeout sets it and wins over an accepted clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stat <= 1'b0;
        else if (zero_hit)
            stat <= 1'b1;
        else if (clr_ok)
            stat <= 1'b0;
    end

    // Busy window: starts on an accepted clear, runs down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_cnt <= '0;
        else if (clr_ok)
            busy_cnt <= BW'(BUSY_CYC);
        else if (clr_busy)
            busy_cnt <= busy_cnt - 1'b1;
    end

    // Reset request: a timeout that finds the previous one still pending.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rst_req <= 1'b0;
        else
            rst_req <= zero_hit && stat && rst_en;
    end

    AST_BUSY_AFTER_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        clr_ok |=> clr_busy); // R7
    AST_BUSY_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_stb && clr_busy && stat) |=> stat); // R7
    AST_RSTREQ_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> stat); // R6
    AST_TIMEOUT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        zero_hit |=> stat); // R5
endmodule

// File: rtl/wdog_timer.sv
// Top of the watchdog. Wires the register file, counter and interrupt logic,
// and applies the mask to the interrupt output. Assumes one synchronous
// clock and reset domain.
module wdog_timer
    import wdog_pkg::*;
#(
    parameter int AW       = ADDR_W,
    parameter int DW       = DATA_W,
    parameter int BUSY_CYC = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [DW-1:0] bus_rdata,
    output logic          irq_o,
    output logic          rst_req_o
);
    logic [DW-1:0] cnt_val;
    logic [DW-1:0] load_val;
    logic          stat, clr_busy, rst_en, cnt_en, mask;
    logic          reload_stb, clr_stb, zero_hit;

    wdog_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .cnt_val(cnt_val), .stat(stat), .clr_busy(clr_busy),
        .rst_en(rst_en), .load_val(load_val), .cnt_en(cnt_en),
        .mask(mask), .reload_stb(reload_stb), .clr_stb(clr_stb)
    );

    wdog_counter #(.CW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .en(cnt_en),
        .reload_stb(reload_stb), .load_val(load_val),
        .cnt(cnt_val), .zero_hit(zero_hit)
    );

    wdog_irq #(.BUSY_CYC(BUSY_CYC)) u_irq (
        .clk(clk), .rst_n(rst_n), .zero_hit(zero_hit),
        .rst_en(rst_en), .clr_stb(clr_stb),
        .stat(stat), .clr_busy(clr_busy), .rst_req(rst_req_o)
    );

    // Interrupt output: status passed through unless masked.
    assign irq_o = stat && !mask;

    AST_MASK_BLOCKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        mask |-> !irq_o); // R8
    AST_IRQ_NEEDS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> stat); // R8
endmodule

// File: tb/wdog_timer_test.sv
module wdog_timer_test;
    localparam int CLK_P = 10;
    localparam int WD_LIMIT = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o, rst_req_o;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 0;

    wdog_timer uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .rst_req_o(rst_req_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // Behavioural reference state.
    bit          m_locked, m_rst_en, m_en, m_mask, m_stat, m_rreq;
    longint      m_load, m_cnt;
    int          m_busy;

    function automatic longint m_read(input logic [11:0] a);
        case (a)
            12'h000: return m_stat;
            12'h104: return m_rst_en;
            12'h108: return m_load;
            12'h110: return m_en;
            12'h118: return m_cnt;
            12'h120: return (m_busy > 0) ? 2 : 0;
            12'h124: return m_mask;
            12'h13C: return m_locked;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model update on each edge from the inputs seen there.
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_locked = 1; m_rst_en = 0; m_en = 0; m_mask = 1; m_stat = 0;
            m_rreq = 0; m_load = 64'hFFFFFFFF; m_cnt = 64'hFFFFFFFF; m_busy = 0;
        end else begin
            bit zero, open, acc;
            longint old_load;
            zero = m_en && (m_cnt == 0);
            open = bus_wr && !m_locked;
            acc  = open && bus_addr == 12'h120 && bus_wdata[0] && m_busy == 0;
            old_load = m_load;
            m_rreq = zero && m_stat && m_rst_en;
            if (open && bus_addr == 12'h114) m_cnt = old_load;
            else if (zero) m_cnt = old_load;
            else if (m_en) m_cnt = m_cnt - 1;
            if (zero) m_stat = 1; else if (acc) m_stat = 0;
            if (acc) m_busy = 2; else if (m_busy > 0) m_busy = m_busy - 1;
            if (open) begin
                case (bus_addr)
                    12'h104: m_rst_en = bus_wdata[0];
                    12'h108: m_load = bus_wdata;
                    12'h110: m_en = bus_wdata[0];
                    12'h124: m_mask = bus_wdata[0];
                    default: ;
                endcase
            end
            if (bus_wr && bus_addr == 12'h13C) m_locked = (bus_wdata != 32'h378F0765);
        end
    end

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(irq_o == (m_stat && !m_mask), "R8 irq_o vs model", irq_o, m_stat && !m_mask);
            chk(rst_req_o == m_rreq, "R6 rst_req_o vs model", rst_req_o, m_rreq);
            if (bus_rd)
                chk(bus_rdata == m_read(bus_addr), "R9 read vs model", bus_rdata, m_read(bus_addr));
            else
                chk(bus_rdata == 0, "R9 idle rdata", bus_rdata, 0);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] v);
        @(posedge clk); #1;
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        v = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        rd(a, v);
        chk(v == exp, tag, v, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog on the run length.
    always @(posedge clk) begin
        if (cyc > WD_LIMIT && !done) begin
            chk(1'b0, "watchdog expired", cyc, WD_LIMIT);
            finish_run();
        end
    end

    initial begin
        logic [31:0] v1, v2;
        int pulses;
        bit back2back;
        logic prev;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // Reset state.
        rd_chk(12'h13C, 32'h1, "R1 locked after reset");
        rd_chk(12'h124, 32'h1, "R9 mask reset");
        rd_chk(12'h108, 32'hFFFFFFFF, "R9 load reset");
        rd_chk(12'h118, 32'hFFFFFFFF, "R9 counter reset");
        rd_chk(12'h110, 32'h0, "R9 enable reset");
        rd_chk(12'h104, 32'h0, "R9 control reset");
        rd_chk(12'h000, 32'h0, "R9 status reset");

        // Writes while locked are dropped.
        wr(12'h108, 32'h5);
        wr(12'h114, 32'h0);
        wr(12'h124, 32'h0);
        rd_chk(12'h108, 32'hFFFFFFFF, "R2 load unchanged while locked");
        rd_chk(12'h118, 32'hFFFFFFFF, "R2 counter unchanged while locked");
        rd_chk(12'h124, 32'h1, "R2 mask unchanged while locked");

        // Wrong key keeps it locked; right key opens it.
        wr(12'h13C, 32'h378F0764);
        rd_chk(12'h13C, 32'h1, "R1 wrong key stays locked");
        wr(12'h13C, 32'h378F0765);
        rd_chk(12'h13C, 32'h0, "R1 key unlocks");

        // Unmapped offsets.
        rd_chk(12'h200, 32'h0, "R9 unmapped 0x200");
        rd_chk(12'h10C, 32'h0, "R9 unmapped 0x10C");

        // Reload copies preset; disabled counter holds.
        wr(12'h108, 32'h5);
        wr(12'h114, 32'h0);
        rd_chk(12'h118, 32'h5, "R4 reload data 0 copies load");
        idle(5);
        rd_chk(12'h118, 32'h5, "R3 disabled counter holds");
        wr(12'h108, 32'h7);
        wr(12'h114, 32'h1);
        rd_chk(12'h118, 32'h7, "R4 reload data 1 copies load");
        wr(12'h108, 32'h5);

        // Run to timeout with interrupt unmasked.
        wr(12'h124, 32'h0);
        wr(12'h110, 32'h1);
        idle(15);
        rd_chk(12'h000, 32'h1, "R5 status set on zero");
        @(negedge clk);
        chk(irq_o == 1'b1, "R8 irq_o with mask clear", irq_o, 1);

        // Stop, clear, observe busy window.
        wr(12'h110, 32'h0);
        wr(12'h120, 32'h1);
        rd_chk(12'h120, 32'h2, "R7 busy right after clear");
        idle(2);
        rd_chk(12'h120, 32'h0, "R7 busy gone");
        rd_chk(12'h000, 32'h0, "R7 status cleared");

        // Masked interrupt.
        wr(12'h124, 32'h1);
        wr(12'h108, 32'h2);
        wr(12'h114, 32'h0);
        wr(12'h110, 32'h1);
        idle(8);
        rd_chk(12'h000, 32'h1, "R8 status pending while masked");
        @(negedge clk);
        chk(irq_o == 1'b0, "R8 irq_o masked", irq_o, 0);

        // Reset request on repeated timeout.
        wr(12'h108, 32'h3);
        wr(12'h104, 32'h1);
        pulses = 0; back2back = 0; prev = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (rst_req_o) pulses++;
            if (rst_req_o && prev) back2back = 1;
            prev = rst_req_o;
        end
        chk(pulses >= 1, "R6 reset request on unserviced timeout", pulses, 1);
        chk(!back2back, "R6 reset request one cycle wide", back2back, 0);

        wr(12'h104, 32'h0);
        wr(12'h120, 32'h1);
        pulses = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (rst_req_o) pulses++;
        end
        chk(pulses == 0, "R6 no reset request when control bit 0", pulses, 0);

        // Relock; disable write ignored, counter keeps running.
        wr(12'h13C, 32'h0);
        rd_chk(12'h13C, 32'h1, "R1 non-key write relocks");
        wr(12'h110, 32'h0);
        rd_chk(12'h110, 32'h1, "R2 enable unchanged while locked");
        rd(12'h118, v1);
        rd(12'h118, v2);
        chk(v1 != v2, "R2 counter still running after locked disable", v2, v1);

        idle(3);
        finish_run();
    end
endmodule